// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block decides, for every transaction address presented to it, which downstream target should receive the transaction. It holds a bank of eight programmable windows. Each window has an enable, a 7-bit target identifier, an inclusive address range at 1 MB granularity, and separate write and read security checks. The decode is purely combinational. It reports whether a window was hit, which window it was, and the resulting target.

Addresses that fall in no enabled window go to a fallback target. Software sets the fallback target in a global register. The security check looks at the secure flag carried by each transaction. A non-secure access that hits a window protected for that direction raises a violation in the same cycle and withholds the target-valid qualifier.

Software programs the windows through a 32-bit register port. Writes are synchronous and reads are combinational. The block routes nothing itself, has no handshake at its edges, and performs no clock-domain crossing.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads 0. Every window is disabled, so any address misses and `target_o` is 0.
- R2: Window n owns word offsets 0x10*n + {0x0 control, 0x4 security, 0x8 low address, 0xC high address}, for n = 0..7. In the control register, bit 0 is the enable and bits [14:8] are the target ID. All other bits read 0.
- R3: In the security register, bit 0 enables the write-secure check and bit 1 enables the read-secure check. Bits [31:2] read 0.
- R4: The low and high address registers keep bits [31:4], which map to address bits [47:20]. Bits [3:0] are discarded and read 0.
- R5: An enabled window matches when low[31:4] <= addr[47:20] <= high[31:4]. The high register names the last 1 MB granule, so the limit is inclusive. Address bits [19:0] never affect the result.
- R6: A disabled window never matches, whatever its address registers hold.
- R7: When several enabled windows match, the one with the lowest index is reported in `hit_win_o` and supplies `target_o`.
- R8: The global register sits at offset 0xD0 and keeps bits [11:8] as the default target. On a miss, `hit_valid_o` is 0 and `target_o` is that value zero-extended to 7 bits.
- R9: A valid, non-secure write that hits a window with write-secure set raises `sec_viol_o` and drops `target_valid_o`. A valid, non-secure read that hits a window with read-secure set does the same. Secure transactions never violate.
- R10: Reads from any other offset return 0, including offsets with a non-zero value in bits [1:0]. Writes to such offsets change nothing.
- R11: `target_valid_o` is high exactly when `txn_valid_i` is high and there is no violation. Both `target_valid_o` and `sec_viol_o` are 0 while `txn_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| txn_valid_i | input | 1 | Transaction present |
| txn_addr_i | input | 48 | Transaction physical address |
| txn_write_i | input | 1 | 1 = write, 0 = read |
| txn_secure_i | input | 1 | Transaction is secure |
| hit_valid_o | output | 1 | Some enabled window matches |
| hit_win_o | output | 3 | Index of the matching window |
| target_o | output | 7 | Selected target ID |
| target_valid_o | output | 1 | Valid transaction with no violation |
| sec_viol_o | output | 1 | Security violation for this transaction |

## Verification
Directed address patterns sit exactly on the first and last byte of a window's range and one granule outside it. Because the limit is inclusive, these patterns show whether each bound is compared with the right operator and whether the low 20 bits are truly ignored. Overlapping windows tell lowest-index priority apart from last-match or highest-index selection. A window that is fully programmed but disabled separates the enable gate from the range compare. All four combinations of direction and security flag, tried against each security bit, show whether a check is tied to the wrong direction. Random windows, clustered in a small granule range so that overlaps and misses are common, then run with random accesses and register rewrites against a bench model of all outputs.

// File: rtl/adw_pkg.sv
package adw_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SEC  = 2'd1,
    REG_LO   = 2'd2,
    REG_HI   = 2'd3
  } win_reg_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_TID_LSB = 8;
  localparam int unsigned SEC_WR_BIT   = 0;
  localparam int unsigned SEC_RD_BIT   = 1;
  localparam int unsigned ADDR_LSB     = 4;
  localparam int unsigned GLOB_DEF_LSB = 8;
  localparam logic [7:0]  GLOB_OFF     = 8'hD0;
  localparam int unsigned WIN_STRIDE   = 16;
endpackage

// File: rtl/adw_win_cmp.sv
module adw_win_cmp #(
  parameter int unsigned GW = 28
) (
  input  logic          en_i,
  input  logic [GW-1:0] gran_i,
  input  logic [GW-1:0] lo_i,
  input  logic [GW-1:0] hi_i,
  output logic          match_o
);
  logic ge_lo, le_hi;
  assign ge_lo   = gran_i >= lo_i;
  assign le_hi   = gran_i <= hi_i;
  assign match_o = en_i & ge_lo & le_hi;
endmodule

// File: rtl/adw_prio_sel.sv
module adw_prio_sel #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    // scan downwards so the lowest index is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/adw_regfile.sv
module adw_regfile
  import adw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned TID_W   = 7,
  parameter int unsigned DEF_W   = 4,
  parameter int unsigned GW      = 28,
  parameter int unsigned RA_W    = 8,
  parameter int unsigned DW      = 32,
  localparam int unsigned IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int unsigned SPAN   = NUM_WIN * WIN_STRIDE
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [RA_W-1:0]                addr_i,
  input  logic [DW-1:0]                  wdata_i,
  output logic [DW-1:0]                  rdata_o,
  output logic [NUM_WIN-1:0]             win_en_o,
  output logic [NUM_WIN-1:0][TID_W-1:0]  win_tid_o,
  output logic [NUM_WIN-1:0]             win_wsec_o,
  output logic [NUM_WIN-1:0]             win_rsec_o,
  output logic [NUM_WIN-1:0][GW-1:0]     win_lo_o,
  output logic [NUM_WIN-1:0][GW-1:0]     win_hi_o,
  output logic [DEF_W-1:0]               dflt_o
);
  logic          in_win, is_glob;
  logic [IW-1:0] win_sel;
  win_reg_e      reg_sel;

  assign in_win  = (int'(addr_i) < SPAN) && (addr_i[1:0] == 2'b00);
  assign is_glob = addr_i == RA_W'(GLOB_OFF);
  assign win_sel = addr_i[4 +: IW];
  assign reg_sel = win_reg_e'(addr_i[3:2]);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic wr_this;
    assign wr_this = we_i && in_win && (win_sel == IW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_en_o[i]   <= 1'b0;
        win_tid_o[i]  <= '0;
        win_wsec_o[i] <= 1'b0;
        win_rsec_o[i] <= 1'b0;
        win_lo_o[i]   <= '0;
        win_hi_o[i]   <= '0;
      end else if (wr_this) begin
        unique case (reg_sel)
          REG_CTRL: begin
            win_en_o[i]  <= wdata_i[CTRL_EN_BIT];
            win_tid_o[i] <= wdata_i[CTRL_TID_LSB +: TID_W];
          end
          REG_SEC: begin
            win_wsec_o[i] <= wdata_i[SEC_WR_BIT];
            win_rsec_o[i] <= wdata_i[SEC_RD_BIT];
          end
          REG_LO:  win_lo_o[i] <= wdata_i[ADDR_LSB +: GW];
          REG_HI:  win_hi_o[i] <= wdata_i[ADDR_LSB +: GW];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dflt_o <= '0;
    else if (we_i && is_glob) dflt_o <= wdata_i[GLOB_DEF_LSB +: DEF_W];
  end

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      unique case (reg_sel)
        REG_CTRL: begin
          rdata_o[CTRL_EN_BIT]            = win_en_o[win_sel];
          rdata_o[CTRL_TID_LSB +: TID_W]  = win_tid_o[win_sel];
        end
        REG_SEC: begin
          rdata_o[SEC_WR_BIT] = win_wsec_o[win_sel];
          rdata_o[SEC_RD_BIT] = win_rsec_o[win_sel];
        end
        REG_LO:  rdata_o[ADDR_LSB +: GW] = win_lo_o[win_sel];
        REG_HI:  rdata_o[ADDR_LSB +: GW] = win_hi_o[win_sel];
        default: ;
      endcase
    end else if (is_glob) begin
      rdata_o[GLOB_DEF_LSB +: DEF_W] = dflt_o;
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned GRAN_SH = 20,
  parameter int unsigned TID_W   = 7,
  parameter int unsigned DEF_W   = 4,
  parameter int unsigned RA_W    = 8,
  parameter int unsigned DW      = 32,
  localparam int unsigned GW     = ADDR_W - GRAN_SH,
  localparam int unsigned IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              txn_valid_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic              txn_write_i,
  input  logic              txn_secure_i,
  output logic              hit_valid_o,
  output logic [IW-1:0]     hit_win_o,
  output logic [TID_W-1:0]  target_o,
  output logic              target_valid_o,
  output logic              sec_viol_o
);
  logic [NUM_WIN-1:0]            win_en, win_wsec, win_rsec, win_match;
  logic [NUM_WIN-1:0][TID_W-1:0] win_tid;
  logic [NUM_WIN-1:0][GW-1:0]    win_lo, win_hi;
  logic [DEF_W-1:0]              dflt;
  logic [GW-1:0]                 gran;
  logic                          prot_hit, viol;
  logic                          unused_ok;

  assign gran      = txn_addr_i[ADDR_W-1:GRAN_SH];
  assign unused_ok = ^{txn_addr_i[GRAN_SH-1:0], reg_wdata_i};

  adw_regfile #(
    .NUM_WIN(NUM_WIN), .TID_W(TID_W), .DEF_W(DEF_W),
    .GW(GW), .RA_W(RA_W), .DW(DW)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .win_en_o   (win_en),
    .win_tid_o  (win_tid),
    .win_wsec_o (win_wsec),
    .win_rsec_o (win_rsec),
    .win_lo_o   (win_lo),
    .win_hi_o   (win_hi),
    .dflt_o     (dflt)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    adw_win_cmp #(.GW(GW)) u_cmp (
      .en_i    (win_en[i]),
      .gran_i  (gran),
      .lo_i    (win_lo[i]),
      .hi_i    (win_hi[i]),
      .match_o (win_match[i])
    );
  end

  adw_prio_sel #(.N(NUM_WIN)) u_prio (
    .req_i (win_match),
    .any_o (hit_valid_o),
    .idx_o (hit_win_o)
  );

  assign target_o = hit_valid_o ? win_tid[hit_win_o] : TID_W'(dflt);

  assign prot_hit = txn_write_i ? win_wsec[hit_win_o] : win_rsec[hit_win_o];
  assign viol     = txn_valid_i && !txn_secure_i && hit_valid_o && prot_hit;

  assign sec_viol_o     = viol;
  assign target_valid_o = txn_valid_i && !viol;
endmodule

// File: rtl/adw_checker.sv
module adw_checker #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned GW      = 28,
  parameter int unsigned TID_W   = 7,
  parameter int unsigned DEF_W   = 4,
  localparam int unsigned IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        txn_valid_i,
  input logic                        txn_secure_i,
  input logic [GW-1:0]               gran,
  input logic                        hit_valid_o,
  input logic [IW-1:0]               hit_win_o,
  input logic [TID_W-1:0]            target_o,
  input logic                        target_valid_o,
  input logic                        sec_viol_o,
  input logic [NUM_WIN-1:0]          win_en,
  input logic [NUM_WIN-1:0][GW-1:0]  win_lo,
  input logic [NUM_WIN-1:0][GW-1:0]  win_hi,
  input logic [DEF_W-1:0]            dflt
);
  AST_HIT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> win_en[hit_win_o]); // R6
  AST_HIT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> (gran >= win_lo[hit_win_o]) && (gran <= win_hi[hit_win_o])); // R5
  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_valid_o |-> target_o == TID_W'(dflt)); // R8
  AST_VIOL_NONSEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_viol_o |-> txn_valid_i && !txn_secure_i && hit_valid_o); // R9
  AST_VIOL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_viol_o |-> !target_valid_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_valid_i |-> !sec_viol_o && !target_valid_o); // R11
endmodule

bind addr_window_decoder adw_checker #(
  .NUM_WIN(NUM_WIN), .GW(GW), .TID_W(TID_W), .DEF_W(DEF_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .txn_valid_i    (txn_valid_i),
  .txn_secure_i   (txn_secure_i),
  .gran           (gran),
  .hit_valid_o    (hit_valid_o),
  .hit_win_o      (hit_win_o),
  .target_o       (target_o),
  .target_valid_o (target_valid_o),
  .sec_viol_o     (sec_viol_o),
  .win_en         (win_en),
  .win_lo         (win_lo),
  .win_hi         (win_hi),
  .dflt           (dflt)
);

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        txn_valid_i = 1'b0;
  logic [47:0] txn_addr_i = '0;
  logic        txn_write_i = 1'b0;
  logic        txn_secure_i = 1'b0;
  logic        hit_valid_o;
  logic [2:0]  hit_win_o;
  logic [6:0]  target_o;
  logic        target_valid_o;
  logic        sec_viol_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_reg [8][4];
  logic [31:0] m_glob;

  always #4 clk_i = ~clk_i;

  addr_window_decoder dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_for(logic [7:0] a, logic [31:0] d);
    if (a < 8'h80 && a[1:0] == 2'b00) begin
      case (a[3:2])
        2'd0:    return d & 32'h0000_7F01;
        2'd1:    return d & 32'h0000_0003;
        default: return d & 32'hFFFF_FFF0;
      endcase
    end
    return d & 32'h0000_0F00;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a < 8'h80 && a[1:0] == 2'b00) return m_reg[a[6:4]][a[3:2]];
    if (a == 8'hD0) return m_glob;
    return 32'h0;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a < 8'h80 && a[1:0] == 2'b00) m_reg[a[6:4]][a[3:2]] = mask_for(a, d);
    else if (a == 8'hD0) m_glob = mask_for(a, d);
  endtask

  task automatic rd(string req, logic [7:0] a);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp_read(a));
  endtask

  task automatic txn(string req, logic v, logic [47:0] ad, logic w, logic s);
    logic       e_hit = 1'b0;
    logic [2:0] e_idx = '0;
    logic [6:0] e_tgt;
    logic       e_viol;
    logic [27:0] g = ad[47:20];
    for (int i = 7; i >= 0; i--) begin
      if (m_reg[i][0][0] && g >= m_reg[i][2][31:4] && g <= m_reg[i][3][31:4]) begin
        e_hit = 1'b1; e_idx = 3'(i);
      end
    end
    e_tgt  = e_hit ? m_reg[e_idx][0][14:8] : {3'b000, m_glob[11:8]};
    e_viol = v && !s && e_hit && (w ? m_reg[e_idx][1][0] : m_reg[e_idx][1][1]);
    @(negedge clk_i);
    txn_valid_i = v; txn_addr_i = ad; txn_write_i = w; txn_secure_i = s;
    #1;
    chk({req, " hit"}, hit_valid_o, e_hit);
    if (e_hit) chk({req, " win"}, hit_win_o, e_idx);
    chk({req, " tgt"}, target_o, e_tgt);
    chk({req, " viol"}, sec_viol_o, e_viol);
    chk({req, " tvalid"}, target_valid_o, v && !e_viol);
  endtask

  function automatic logic [47:0] ga(int g, logic [19:0] lo_bits);
    return {28'(g), lo_bits};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    foreach (m_reg[i, j]) m_reg[i][j] = '0;
    m_glob = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd("R1 ctrl0", 8'h00); rd("R1 hi7", 8'h7C); rd("R1 glob", 8'hD0);
    txn("R1 miss", 1'b1, ga(16'h0123, 20'h0), 1'b0, 1'b0);

    // R8 default target
    wr(8'hD0, 32'hFFFF_FFFF);
    rd("R8 glob rb", 8'hD0);
    txn("R8 miss dflt", 1'b1, ga(16'h0500, 20'h1), 1'b1, 1'b1);

    // R2 / R3 / R4 field masks
    wr(8'h20, 32'hFFFF_FFFE); rd("R2 ctrl mask", 8'h20);
    wr(8'h24, 32'hFFFF_FFFF); rd("R3 sec mask", 8'h24);
    wr(8'h28, 32'hFFFF_FFFF); rd("R4 lo mask", 8'h28);
    wr(8'h20, 32'h0); wr(8'h24, 32'h0); wr(8'h28, 32'h0);

    // R6 disabled window, then R5 boundaries
    wr(8'h08, 32'h0000_100F);  // granule 0x100, nibble dropped
    wr(8'h0C, 32'h0000_10F0);  // last granule 0x10F
    wr(8'h00, 32'h0000_5500);
    txn("R6 disabled", 1'b1, ga(16'h0105, 20'h0), 1'b0, 1'b0);
    wr(8'h00, 32'h0000_5501);
    txn("R5 first byte", 1'b1, ga(16'h0100, 20'h00000), 1'b0, 1'b0);
    txn("R5 last byte",  1'b1, ga(16'h010F, 20'hFFFFF), 1'b0, 1'b0);
    txn("R5 above",      1'b1, ga(16'h0110, 20'h00000), 1'b0, 1'b0);
    txn("R5 below",      1'b1, ga(16'h00FF, 20'hFFFFF), 1'b0, 1'b0);

    // R7 overlap priority
    wr(8'h38, 32'h0000_1080); wr(8'h3C, 32'h0000_2000); wr(8'h30, 32'h0000_2201);
    txn("R7 overlap low wins", 1'b1, ga(16'h0108, 20'h4), 1'b0, 1'b0);
    txn("R7 only win3",        1'b1, ga(16'h0150, 20'h4), 1'b0, 1'b0);

    // R9 / R11 security
    wr(8'h34, 32'h1);
    txn("R9 ns write wsec", 1'b1, ga(16'h0150, 20'h0), 1'b1, 1'b0);
    txn("R9 ns read wsec",  1'b1, ga(16'h0150, 20'h0), 1'b0, 1'b0);
    txn("R9 s write wsec",  1'b1, ga(16'h0150, 20'h0), 1'b1, 1'b1);
    txn("R11 idle",         1'b0, ga(16'h0150, 20'h0), 1'b1, 1'b0);
    wr(8'h34, 32'h2);
    txn("R9 ns read rsec",  1'b1, ga(16'h0150, 20'h0), 1'b0, 1'b0);
    txn("R9 ns write rsec", 1'b1, ga(16'h0150, 20'h0), 1'b1, 1'b0);

    // R10 unmapped offsets
    wr(8'h84, 32'hFFFF_FFFF); rd("R10 0x84", 8'h84);
    wr(8'hD4, 32'hFFFF_FFFF); rd("R10 0xD4", 8'hD4);
    wr(8'h01, 32'h0);         rd("R10 0x01", 8'h01);
    rd("R10 ctrl0 kept", 8'h00); rd("R10 glob kept", 8'hD0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        int w = $urandom_range(0, 7);
        int s = $urandom_range(0, 3);
        logic [31:0] d = $urandom();
        if (s >= 2) d = {4'h0, 20'h0, 8'($urandom_range(0, 255)), d[3:0]};
        if (s == 0 && $urandom_range(0, 1) == 0) d[0] = 1'b1;
        wr(8'(w * 16 + s * 4), d);
        rd("R2 rand rb", 8'(w * 16 + s * 4));
      end
      if ($urandom_range(0, 15) == 0) wr(8'hD0, $urandom());
      txn("R5 R7 R9 rand", 1'($urandom_range(0, 7) != 0),
          ga($urandom_range(0, 300), 20'($urandom())),
          1'($urandom()), 1'($urandom()));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule